// File: doc/BRIEF.md
# Byte-Sequenced I2C Master

This block is an I2C master that software steps through a bus transaction one byte at a time. Software loads a byte into the data register and then writes the control register. The control byte says whether a start condition comes before the byte, whether a stop condition follows it, which way the byte travels, and whether completion raises an interrupt. Setting the launch bit in the same write runs that single byte on the bus. The byte includes its acknowledge slot. When the byte is done, the launch bit reads back as clear.

The first byte of a transaction is the device address: seven address bits in bits 7..1, and bit 0 set to 1 for a read. A byte launched without a stop leaves the master holding SCL low and owning the bus. Launching a start on an owned bus then produces a repeated start. A pause request combined with a stop ends a failed transaction by sending only the stop condition.

The bus pins are open-drain: an output high means "pull the line low". SCL runs at a fixed fraction of the system clock. Each SCL bit time is split into four equal quarters of `CLK_HZ/(4*SCL_HZ)` cycles.

Top module: `i2cbm_top`

## Requirements
- R1: After reset the control readback and the data register are 0x00, both bus lines are released and the interrupt output is low.
- R2: A control write with bit 7 set makes bit 7 read 1 from the next cycle until the byte finishes. While bit 7 reads 1, writes to the data or control register have no effect.
- R3: With control bit 1 set, an SDA fall while SCL is high (start) comes before the byte. The byte is sent most significant bit first. A byte launched with bit 1 set is always transmitted, whatever bit 5 says.
- R4: Launching with bit 1 set while the bus is still owned from a byte without a stop produces a repeated start, with no stop in between.
- R5: With control bit 0 set, the byte and its acknowledge slot are followed by a stop (SDA rises while SCL is high). The master then releases both lines.
- R6: A byte launched without bit 0 ends with the master holding SCL low. No stop is generated.
- R7: On a transmitted byte, control bit 4 reads the slave's answer when the byte completes: 1 for ACK (SDA low), 0 for NACK.
- R8: With bit 5 set (read) and bit 1 clear, eight bits are sampled MSB first. They are in the data register when bit 7 clears. The master drives ACK in the ninth slot if bit 4 was written 1, and NACK if bit 4 was written 0.
- R9: Control bit 2 (pause) together with bit 0 on an owned bus sends only a stop, with a single SCL release and no data bits. Pause without a stop causes no bus activity, and the byte completes at once.
- R10: During data and acknowledge bits, SDA changes only while SCL is low. The only SDA edges while SCL is high are the requested start and stop conditions.
- R11: When a byte completes with bit 6 set, the interrupt output goes high and stays high until the next accepted control write. With bit 6 clear it stays low.
- R12: Consecutive SCL rising edges within a byte are 4*(CLK_HZ/(4*SCL_HZ)) clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_ctrl_i | input | 1 | Write target: 1 = control register, 0 = data register |
| wr_data_i | input | 8 | Write data |
| data_o | output | 8 | Data register readback (received byte after a read) |
| ctrl_o | output | 8 | Control readback: 7 busy, 6 irq enable, 5 read, 4 ack, 2 pause, 1 start, 0 stop |
| irq_o | output | 1 | Completion interrupt, latched |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The busy bit is due one clock after the launching control write. Write rejection shows in the readback one clock after the attempted write. The ACK status, the received byte, the interrupt and the final state of the bus lines all change in the same clock edge that clears busy.

The bench therefore polls busy on falling clock edges and samples every completion result on the first falling edge at which busy reads 0. An SCL pulse counter and a start/stop detector in the slave model are read only after that point. The SCL spacing is taken from the clock counts of the last two rising edges of a byte.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

    typedef enum logic [2:0] {
        E_IDLE  = 3'd0,
        E_START = 3'd1,
        E_BIT   = 3'd2,
        E_ACK   = 3'd3,
        E_STOP  = 3'd4
    } eng_st_t;

    // control register bit positions
    localparam int C_STOP  = 0;
    localparam int C_START = 1;
    localparam int C_PAUSE = 2;
    localparam int C_ACK   = 4;
    localparam int C_READ  = 5;
    localparam int C_IE    = 6;
    localparam int C_BUSY  = 7;

    typedef struct packed {
        eng_st_t    st;
        logic [1:0] ph;
        logic [2:0] bitn;
        logic [7:0] tx;
        logic [7:0] rx;
        logic       owned;
        logic       rd;
        logic       stop;
        logic       ack_tx;
        logic       ack_rx;
        logic       done;
        logic       scl_low;
        logic       sda_low;
    } eng_t;

    typedef struct packed {
        logic [7:0] data;
        logic       stop;
        logic       start;
        logic       pause;
        logic       ack;
        logic       rd;
        logic       ie;
        logic       busy;
        logic       irq;
    } regs_t;

    // Line drive for a given sequencer position: {scl_low, sda_low}
    function automatic logic [1:0] bus_drive(eng_st_t st, logic [1:0] ph, logic owned,
                                             logic rd, logic tx7, logic ack_tx);
        logic scl_l;
        logic sda_l;
        scl_l = 1'b0;
        sda_l = 1'b0;
        case (st)
            E_IDLE: begin
                scl_l = owned;
            end
            E_START: begin
                case (ph)
                    2'd0:    scl_l = owned;
                    2'd1:    scl_l = 1'b0;
                    2'd2:    sda_l = 1'b1;
                    default: begin scl_l = 1'b1; sda_l = 1'b1; end
                endcase
            end
            E_BIT: begin
                scl_l = (ph == 2'd0) || (ph == 2'd3);
                sda_l = !rd && !tx7;
            end
            E_ACK: begin
                scl_l = (ph == 2'd0) || (ph == 2'd3);
                sda_l = rd && ack_tx;
            end
            E_STOP: begin
                scl_l = (ph == 2'd0);
                sda_l = (ph == 2'd0) || (ph == 2'd1);
            end
            default: begin
                scl_l = 1'b0;
                sda_l = 1'b0;
            end
        endcase
        return {scl_l, sda_l};
    endfunction

endpackage

// File: rtl/i2cbm_tick.sv
module i2cbm_tick #(
    parameter int QDIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST) && !clr_i;
endmodule

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/i2cbm_engine.sv
module i2cbm_engine
    import i2cbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       pause_i,
    input  logic       rd_i,
    input  logic       ack_tx_i,
    input  logic [7:0] tx_i,
    input  logic       tick_i,
    input  logic       sda_i,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       ack_rx_o,
    output logic       scl_low_o,
    output logic       sda_low_o
);
    eng_t q, d;
    logic [1:0] drv;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.st == E_IDLE) begin
            if (go_i) begin
                d.rd     = rd_i && !start_i;
                d.stop   = stop_i;
                d.ack_tx = ack_tx_i;
                d.tx     = tx_i;
                d.ph     = 2'd0;
                d.bitn   = 3'd7;
                if (pause_i) begin
                    if (stop_i && q.owned) d.st = E_STOP;
                    else                   d.done = 1'b1;
                end else if (start_i) begin
                    d.st = E_START;
                end else begin
                    d.st = E_BIT;
                end
            end
        end else if (tick_i) begin
            d.ph = q.ph + 2'd1;
            case (q.st)
                E_START: begin
                    if (q.ph == 2'd3) begin
                        d.st    = E_BIT;
                        d.bitn  = 3'd7;
                        d.owned = 1'b1;
                    end
                end
                E_BIT: begin
                    if (q.ph == 2'd2) d.rx = {q.rx[6:0], sda_i};
                    if (q.ph == 2'd3) begin
                        d.tx = {q.tx[6:0], 1'b0};
                        if (q.bitn == 3'd0) d.st = E_ACK;
                        else                d.bitn = q.bitn - 3'd1;
                    end
                end
                E_ACK: begin
                    if (q.ph == 2'd2) d.ack_rx = !sda_i;
                    if (q.ph == 2'd3) begin
                        if (q.stop) begin
                            d.st = E_STOP;
                        end else begin
                            d.st    = E_IDLE;
                            d.owned = 1'b1;
                            d.done  = 1'b1;
                        end
                    end
                end
                E_STOP: begin
                    if (q.ph == 2'd3) begin
                        d.st    = E_IDLE;
                        d.owned = 1'b0;
                        d.done  = 1'b1;
                    end
                end
                default: d.st = E_IDLE;
            endcase
        end
        drv       = bus_drive(d.st, d.ph, d.owned, d.rd, d.tx[7], d.ack_tx);
        d.scl_low = drv[1];
        d.sda_low = drv[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o    = q.done;
    assign rx_o      = q.rx;
    assign ack_rx_o  = q.ack_rx;
    assign scl_low_o = q.scl_low;
    assign sda_low_o = q.sda_low;

    // R10: SDA held while SCL is high inside data/ack bits
    a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.scl_low && !$past(q.scl_low) &&
         (q.st == E_BIT || q.st == E_ACK) &&
         ($past(q.st) == E_BIT || $past(q.st) == E_ACK))
        |-> $stable(q.sda_low));

    // R5: an idle, unowned bus is fully released
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == E_IDLE && !q.owned) |-> (!q.scl_low && !q.sda_low));
endmodule

// File: rtl/i2cbm_top.sv
module i2cbm_top
    import i2cbm_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic       wr_ctrl_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] data_o,
    output logic [7:0] ctrl_o,
    output logic       irq_o,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    input  logic       sda_i
);
    localparam int QDIV_RAW = CLK_HZ / (4 * SCL_HZ);
    localparam int QDIV     = (QDIV_RAW < 2) ? 2 : QDIV_RAW;

    regs_t      q, d;
    logic       go;
    logic       tick;
    logic       sda_s;
    logic       done;
    logic [7:0] rx;
    logic       ack_rx;

    always_comb begin
        d  = q;
        go = 1'b0;
        if (wr_en_i && !q.busy) begin
            if (wr_ctrl_i) begin
                d.stop  = wr_data_i[C_STOP];
                d.start = wr_data_i[C_START];
                d.pause = wr_data_i[C_PAUSE];
                d.ack   = wr_data_i[C_ACK];
                d.rd    = wr_data_i[C_READ];
                d.ie    = wr_data_i[C_IE];
                d.busy  = wr_data_i[C_BUSY];
                d.irq   = 1'b0;
                go      = wr_data_i[C_BUSY];
            end else begin
                d.data = wr_data_i;
            end
        end
        if (done) begin
            d.busy = 1'b0;
            if (!q.pause) begin
                if (q.rd && !q.start) d.data = rx;
                else                  d.ack  = ack_rx;
            end
            if (q.ie) d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    i2cbm_tick #(.QDIV(QDIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (go),
        .tick_o (tick)
    );

    i2cbm_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sda_i),
        .q_o   (sda_s)
    );

    i2cbm_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .start_i   (wr_data_i[C_START]),
        .stop_i    (wr_data_i[C_STOP]),
        .pause_i   (wr_data_i[C_PAUSE]),
        .rd_i      (wr_data_i[C_READ]),
        .ack_tx_i  (wr_data_i[C_ACK]),
        .tx_i      (q.data),
        .tick_i    (tick),
        .sda_i     (sda_s),
        .done_o    (done),
        .rx_o      (rx),
        .ack_rx_o  (ack_rx),
        .scl_low_o (scl_oe_o),
        .sda_low_o (sda_oe_o)
    );

    assign data_o = q.data;
    assign ctrl_o = {q.busy, q.ie, q.rd, q.ack, 1'b0, q.pause, q.start, q.stop};
    assign irq_o  = q.irq;

    // R2: busy only falls on an engine completion
    a_r2_busy_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(done));

    // R2: data register holds against writes while busy
    a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && q.busy && !done) |=> (q.data == $past(q.data)) && (q.ie == $past(q.ie)));

    // R11: interrupt rises only from a completion with enable set
    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> ($past(done) && $past(q.ie)));
endmodule

// File: tb/tb_i2cbm_top.sv
module tb_i2cbm_top;
    localparam int CLK_HZ = 100_000_000;
    localparam int SCL_HZ = 2_500_000;
    localparam int QDIV   = CLK_HZ / (4 * SCL_HZ);
    localparam logic [6:0] SLV = 7'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] data_o;
    logic [7:0] ctrl_o;
    logic       irq;
    logic       scl_oe;
    logic       sda_oe;
    logic       s_low = 1'b0;
    logic       scl_w;
    logic       sda_w;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || s_low);

    i2cbm_top #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_ctrl_i (wr_ctrl),
        .wr_data_i (wr_data),
        .data_o    (data_o),
        .ctrl_o    (ctrl_o),
        .irq_o     (irq),
        .scl_oe_o  (scl_oe),
        .sda_oe_o  (sda_oe),
        .sda_i     (sda_w)
    );

    // ---------------- slave model ----------------
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       active = 1'b0, addr_ph = 1'b0, rd_mode = 1'b0, was_addr;
    logic       s_nack = 1'b0, s_mack = 1'b0;
    logic [7:0] s_rx = 8'h00, s_last = 8'h00, s_sh = 8'h00;
    logic [7:0] rd_list [2];
    int         rd_idx = 0, bitcnt = 0;
    int         starts = 0, stops = 0, edges = 0;
    int         rise_prev = 0, rise_last = 0;

    always @(scl_w or sda_w) begin
        if (scl_w && p_scl && p_sda && !sda_w) begin
            starts++; active = 1'b1; addr_ph = 1'b1; rd_mode = 1'b0; bitcnt = 0;
        end else if (scl_w && p_scl && !p_sda && sda_w) begin
            stops++; active = 1'b0; s_low = 1'b0;
        end else if (scl_w && !p_scl) begin
            edges++; rise_prev = rise_last; rise_last = cyc;
            if (active) begin
                if (bitcnt < 8) s_rx = {s_rx[6:0], sda_w};
                else if (rd_mode && !addr_ph) s_mack = !sda_w;
                bitcnt++;
            end
        end else if (!scl_w && p_scl && active) begin
            if (bitcnt == 8) begin
                if (rd_mode && !addr_ph) begin
                    s_low = 1'b0;
                end else begin
                    s_last = s_rx;
                    if (addr_ph) begin
                        rd_mode = s_rx[0];
                        s_low   = (s_rx[7:1] == SLV);
                    end else begin
                        s_low = !s_nack;
                    end
                end
            end else if (bitcnt == 9) begin
                bitcnt   = 0;
                was_addr = addr_ph;
                addr_ph  = 1'b0;
                if (rd_mode && (was_addr || s_mack)) begin
                    s_sh   = rd_list[rd_idx % 2];
                    rd_idx++;
                    s_low  = !s_sh[7];
                end else begin
                    s_low = 1'b0;
                end
            end else if (rd_mode && !addr_ph && bitcnt >= 1 && bitcnt <= 7) begin
                s_low = !s_sh[7 - bitcnt];
            end
        end
        p_scl = scl_w;
        p_sda = sda_w;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic is_ctrl, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = is_ctrl; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!ctrl_o[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic run_byte(input logic [7:0] dv, input logic [7:0] cv);
        wr(1'b0, dv);
        wr(1'b1, cv);
        wait_idle();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(ctrl_o == 8'h00, "R1 ctrl", ctrl_o, 0);
        chk(data_o == 8'h00, "R1 data", data_o, 0);
        chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_address_write();
        wr(1'b0, 8'hA4);
        wr(1'b1, 8'hC2);
        chk(ctrl_o[7] == 1'b1, "R2 busy set", ctrl_o[7], 1);
        wr(1'b0, 8'h11);
        chk(data_o == 8'hA4, "R2 data write ignored", data_o, 8'hA4);
        wait_idle();
        chk(ctrl_o[7] == 1'b0, "R2 busy cleared", ctrl_o[7], 0);
        chk(starts == 1, "R3 start seen", starts, 1);
        chk(s_last == 8'hA4, "R3 byte MSB first", s_last, 8'hA4);
        chk(ctrl_o[4] == 1'b1, "R7 ack reported", ctrl_o[4], 1);
        chk(irq == 1'b1, "R11 irq latched", irq, 1);
        chk(scl_oe == 1'b1 && stops == 0, "R6 bus held", {scl_oe, 8'(stops)}, 9'h100);
        chk(rise_last - rise_prev == 4 * QDIV, "R12 scl period", rise_last - rise_prev, 4 * QDIV);
    endtask

    task automatic t_write_nack_stop();
        s_nack = 1'b1;
        run_byte(8'h3C, 8'h81);
        chk(irq == 1'b0, "R11 irq cleared and not reraised", irq, 0);
        chk(ctrl_o[4] == 1'b0, "R7 nack reported", ctrl_o[4], 0);
        chk(s_last == 8'h3C, "R7 data byte", s_last, 8'h3C);
        chk(stops == 1, "R5 stop seen", stops, 1);
        chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
        s_nack = 1'b0;
    endtask

    task automatic t_restart_read();
        int st0;
        int sp0;
        rd_list[0] = 8'h5A;
        rd_list[1] = 8'hC3;
        rd_idx = 0;
        run_byte(8'hA4, 8'h82);
        st0 = starts;
        sp0 = stops;
        run_byte(8'hA5, 8'h82);
        chk(starts == st0 + 1 && stops == sp0, "R4 repeated start", starts - st0, 1);
        run_byte(8'h00, 8'hB0);
        chk(data_o == 8'h5A, "R8 read byte 1", data_o, 8'h5A);
        chk(s_mack == 1'b1, "R8 master ack", s_mack, 1);
        run_byte(8'h00, 8'hA1);
        chk(data_o == 8'hC3, "R8 read byte 2", data_o, 8'hC3);
        chk(s_mack == 1'b0, "R8 master nack", s_mack, 0);
        chk(stops == sp0 + 1, "R5 stop after read", stops - sp0, 1);
    endtask

    task automatic t_pause();
        int e0;
        int s0;
        int st0;
        run_byte(8'hA4, 8'h82);
        e0 = edges;
        s0 = stops;
        run_byte(8'h00, 8'h85);
        chk(stops == s0 + 1, "R9 pause stop", stops - s0, 1);
        chk(edges == e0 + 1, "R9 no data clocks", edges - e0, 1);
        e0 = edges;
        st0 = starts;
        run_byte(8'h00, 8'h84);
        chk(edges == e0 && starts == st0, "R9 pause idle no activity", edges - e0, 0);
        chk(ctrl_o[7] == 1'b0 && !scl_oe && !sda_oe, "R9 pause done", ctrl_o, 8'h04);
    endtask

    task automatic t_conditions_total();
        chk(starts == 4, "R10 only requested starts", starts, 4);
        chk(stops == 3, "R10 only requested stops", stops, 3);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_address_write();
        t_write_nack_stop();
        t_restart_read();
        t_pause();
        t_conditions_total();
        finish_run();
    end
endmodule